// File: doc/BRIEF.md
# Vector Bit Gather Unit

This unit builds a 16-bit mask by pulling single bits out of a 128-bit source vector. A second 128-bit operand holds sixteen byte-wide indices; each index names one source bit, and the sixteen chosen bits are packed into the mask. The mask is then placed at a fixed spot inside a 128-bit result whose other bits are all zero.

Operands arrive over a valid/ready handshake. The bit selection is purely combinational. Its outcome is captured in a result register one cycle after the handshake, and that register has its own valid flag. A result is held until the consumer accepts it. The input side stalls only while a result is waiting and the consumer is not taking it in that cycle. A 12-bit modifier operand travels with each request and is ignored.

Top module: `bit_gather_unit`

## Requirements
- R1: Index byte lane j of `in_idx` is bits [127-8j -: 8], for j from 0 to 15. Lane 0 supplies the most significant mask bit and lane 15 supplies the least significant mask bit.
- R2: An index value k below 128 selects source bit `in_src[127-k]`, so index 0 picks bit 127 and index 127 picks bit 0.
- R3: An index value of 128 or more contributes a 0 to the mask, whatever the source holds.
- R4: The upper mask byte is written to result byte lane 6, which is `out_data[79:72]`. The lower mask byte is written to lane 7, which is `out_data[71:64]`. Lanes are numbered from the most significant end.
- R5: Every result bit outside `out_data[79:64]` is zero while `out_valid` is high.
- R6: The value of `in_mod` has no effect on the result.
- R7: When `in_valid` and `in_ready` are both high at a clock edge, `out_valid` is high and `out_data` holds the result for those operands after that edge.
- R8: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_data`.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R11: If the result is accepted in a cycle with no new input, `out_valid` falls after the edge. If a new input is taken in the same cycle, the new result replaces the old one with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Unit can take operands this cycle |
| in_src | input | 128 | Source vector the bits are taken from |
| in_idx | input | 128 | Sixteen byte-wide bit indices |
| in_mod | input | 12 | Modifier fields, ignored |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result with the mask in bytes 6 and 7 |

## Verification
The two events that can fall in one cycle are the consumer taking the held result and a new operand pair being accepted. When both happen, the result register must load the new mask and must not drop `out_valid`. The bench causes this by first stalling the output with new operands pending, then raising `out_ready` while `in_valid` is still high. A random phase repeats the overlap many times. A behavioural model, updated at each edge from the handshake it observes, predicts `in_ready`, `out_valid` and `out_data` every cycle, and the design's outputs are judged against it.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

    localparam int VEC_W        = 128;
    localparam int LANE_W       = 8;
    localparam int LANES        = VEC_W / LANE_W;
    localparam int MASK_W       = LANES;
    localparam int MOD_W        = 12;
    localparam int MASK_HI_LANE = 6;
    localparam int MASK_POS     = VEC_W - MASK_HI_LANE * LANE_W - MASK_W;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        vec_t src;
        vec_t idx;
    } operand_t;

    // Byte lane j counted from the most significant end.
    function automatic lane_t lane_of(input vec_t v, input int j);
        return v[VEC_W-1-j*LANE_W -: LANE_W];
    endfunction

    // Result vector with the mask in its fixed byte pair, all else zero.
    function automatic vec_t place_mask(input mask_t m);
        vec_t r;
        r = '0;
        r[MASK_POS +: MASK_W] = m;
        return r;
    endfunction

endpackage

// File: rtl/bg_lane_pick.sv
module bg_lane_pick #(
    parameter int SRC_W = 128,
    parameter int IDX_W = 8
) (
    input  logic [SRC_W-1:0] src,
    input  logic [IDX_W-1:0] index,
    output logic             bit_o
);
    localparam int POS_W = $clog2(SRC_W);
    localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(SRC_W);
    localparam logic [POS_W-1:0] TOP   = POS_W'(SRC_W - 1);

    logic             in_range;
    logic [POS_W-1:0] pos;

    always_comb begin
        in_range = ({1'b0, index} < LIMIT);
        pos      = TOP - index[POS_W-1:0];
        bit_o    = in_range ? src[pos] : 1'b0;
    end

endmodule

// File: rtl/bg_gather.sv
module bg_gather
    import vbg_pkg::*;
(
    input  operand_t op,
    output vec_t     result
);
    mask_t mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t lane_idx;
        assign lane_idx = lane_of(op.idx, g);

        bg_lane_pick #(
            .SRC_W (VEC_W),
            .IDX_W (LANE_W)
        ) u_pick (
            .src   (op.src),
            .index (lane_idx),
            .bit_o (mask[MASK_W-1-g])
        );
    end

    assign result = place_mask(mask);

endmodule

// File: rtl/bg_out_stage.sv
module bg_out_stage
    import vbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  vec_t load_data,
    input  logic out_ready,
    output logic can_load,
    output logic out_valid,
    output vec_t out_data
);
    logic rst_d;

    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) rst_d <= rst;

    // R9: right after reset the register is empty
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            assert_reset_clear_R9: assert (!out_valid && out_data == '0)
                else $error("result register not cleared by reset");
        end
    end

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (out_valid && out_data == $past(load_data)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_drain_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !load) |=> !out_valid);

    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !load);

endmodule

// File: rtl/bit_gather_unit.sv
module bit_gather_unit
    import vbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  in_src,
    input  logic [VEC_W-1:0]  in_idx,
    input  logic [MOD_W-1:0]  in_mod,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VEC_W-1:0]  out_data
);
    operand_t op;
    vec_t     gathered;
    logic     load;
    logic     unused_mod;

    assign op         = '{src: in_src, idx: in_idx};
    assign unused_mod = ^in_mod;
    assign load       = in_valid && in_ready;

    bg_gather u_gather (
        .op     (op),
        .result (gathered)
    );

    bg_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (gathered),
        .out_ready (out_ready),
        .can_load  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assert_zero_bytes_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[VEC_W-1:MASK_POS+MASK_W] == '0 &&
                       out_data[MASK_POS-1:0] == '0));

endmodule

// File: tb/bit_gather_unit_test.sv
module bit_gather_unit_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_src;
    logic [127:0] in_idx;
    logic [11:0]  in_mod;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] out_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 0;

    bit           m_valid;
    logic [127:0] m_data;
    logic [127:0] got;

    always #2 clk = ~clk;

    bit_gather_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_src    (in_src),
        .in_idx    (in_idx),
        .in_mod    (in_mod),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // Behavioural reference: mask bit (15-j) is source bit 127-k of lane j's index k.
    function automatic logic [127:0] ref_gather(input logic [127:0] s, input logic [127:0] ix);
        logic [15:0] m;
        m = '0;
        for (int j = 0; j < 16; j++) begin
            int k;
            k = int'(ix[127 - 8*j -: 8]);
            if (k < 128) m[15 - j] = s[127 - k];
        end
        return {48'h0, m, 64'h0};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic step();
        bit acc;
        bit exp_ready;
        #1;
        exp_ready = !m_valid || out_ready;
        if (!rst)
            check(in_ready === exp_ready, "R8 in_ready", 128'(in_ready), 128'(exp_ready));
        acc = !rst && in_valid && exp_ready;
        @(posedge clk);
        if (rst) begin
            m_valid = 0;
            m_data  = '0;
        end else if (acc) begin
            m_valid = 1;
            m_data  = ref_gather(in_src, in_idx);
        end else if (m_valid && out_ready) begin
            m_valid = 0;
        end
        @(negedge clk);
        check(out_valid === m_valid, "R7 out_valid", 128'(out_valid), 128'(m_valid));
        if (m_valid)
            check(out_data === m_data, "R7 out_data", out_data, m_data);
    endtask

    task automatic send(input logic [127:0] s, input logic [127:0] ix, input logic [11:0] md);
        in_src = s; in_idx = ix; in_mod = md;
        in_valid = 1; out_ready = 1;
        step();
        got = out_data;
        in_valid = 0;
        step();
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] a, b, held;
        rst = 1; in_valid = 0; out_ready = 0;
        in_src = '0; in_idx = '0; in_mod = '0;
        m_valid = 0; m_data = '0;
        step(); step();
        rst = 0;
        check(out_valid === 1'b0 && out_data === '0, "R9 reset state", out_data, 128'h0);
        step();

        // R2: index 0 picks bit 127
        send({1'b1, 127'b0}, {16{8'h00}}, 12'h000);
        check(got === {48'h0, 16'hFFFF, 64'h0}, "R2 index 0", got, {48'h0, 16'hFFFF, 64'h0});
        send(128'h1 << 122, {16{8'h05}}, 12'h000);
        check(got === {48'h0, 16'hFFFF, 64'h0}, "R2 index 5", got, {48'h0, 16'hFFFF, 64'h0});
        send(128'h1 << 122, {16{8'h06}}, 12'h000);
        check(got === 128'h0, "R2 index 6 neighbour", got, 128'h0);

        // R1: lane order
        send({1'b1, 127'b0}, {8'h00, {15{8'h01}}}, 12'h000);
        check(got === {48'h0, 16'h8000, 64'h0}, "R1 lane 0 to msb", got, {48'h0, 16'h8000, 64'h0});
        send({1'b1, 127'b0}, {{15{8'h01}}, 8'h00}, 12'h000);
        check(got === {48'h0, 16'h0001, 64'h0}, "R1 lane 15 to lsb", got, {48'h0, 16'h0001, 64'h0});

        // R4: byte placement
        send({1'b1, 127'b0}, {8'h00, {14{8'h01}}, 8'h00}, 12'h000);
        check(got[79:72] === 8'h80, "R4 byte lane 6", 128'(got[79:72]), 128'h80);
        check(got[71:64] === 8'h01, "R4 byte lane 7", 128'(got[71:64]), 128'h01);

        // R3: out of range indices
        send({128{1'b1}}, {16{8'h80}}, 12'h000);
        check(got === 128'h0, "R3 index 128", got, 128'h0);
        send({128{1'b1}}, {16{8'hFF}}, 12'h000);
        check(got === 128'h0, "R3 index 255", got, 128'h0);
        send({128{1'b1}}, {16{8'h7F}}, 12'h000);
        check(got === {48'h0, 16'hFFFF, 64'h0}, "R3 index 127 in range", got, {48'h0, 16'hFFFF, 64'h0});
        send(128'h1, {8{8'h7F, 8'h80}}, 12'h000);
        check(got === {48'h0, 16'hAAAA, 64'h0}, "R3 mixed range", got, {48'h0, 16'hAAAA, 64'h0});

        // R5: only the mask bytes may be set
        send({128{1'b1}}, {16{8'h00}}, 12'h000);
        check(got[127:80] === '0 && got[63:0] === '0, "R5 other bytes zero", got, {48'h0, 16'hFFFF, 64'h0});

        // R6: modifier ignored
        send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
             128'h00_11_22_33_44_55_66_77_7F_80_90_0A_1B_2C_3D_4E, 12'h000);
        a = got;
        send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
             128'h00_11_22_33_44_55_66_77_7F_80_90_0A_1B_2C_3D_4E, 12'hFFF);
        b = got;
        check(a === b, "R6 modifier ignored", b, a);

        // R10 / R8: stall, then R11 simultaneous drain and accept
        in_src = {1'b1, 127'b0}; in_idx = {16{8'h00}}; in_mod = 12'h5A5;
        in_valid = 1; out_ready = 0;
        step();
        held = out_data;
        in_src = '0; in_idx = {16{8'h80}};
        for (int c = 0; c < 4; c++) begin
            step();
            check(in_ready === 1'b0, "R8 stalled input", 128'(in_ready), 128'h0);
            check(out_valid === 1'b1 && out_data === held, "R10 held result", out_data, held);
        end
        out_ready = 1;
        step();
        check(out_valid === 1'b1 && out_data === 128'h0, "R11 back to back", out_data, 128'h0);
        in_valid = 0;
        step();
        check(out_valid === 1'b0, "R11 drain", 128'(out_valid), 128'h0);

        // Random traffic with overlapping handshakes
        for (int c = 0; c < 400; c++) begin
            in_valid  = ($urandom_range(0, 3) != 0);
            out_ready = ($urandom_range(0, 2) != 0);
            in_src    = {$urandom, $urandom, $urandom, $urandom};
            in_idx    = {$urandom, $urandom, $urandom, $urandom} & {16{8'h87}};
            in_mod    = 12'($urandom);
            step();
        end

        // R9: reset with a result held
        in_valid = 1; out_ready = 0; in_src = {128{1'b1}}; in_idx = '0;
        step();
        rst = 1; in_valid = 0;
        step();
        check(out_valid === 1'b0 && out_data === '0, "R9 reset clears held result", out_data, 128'h0);
        rst = 0;
        step();

        finish_run();
    end

endmodule